// File: doc/BRIEF.md
# Video Shift-Word Pixel Serializer

This block sits between the serial port of a dual-ported video memory and the pixel path of a display. The memory presents one wide word on its shift-out pins. The block picks individual pixels out of that word, one per dot-clock enable. After the last pixel of the word has gone out, it asks the memory for the next word by raising a shift-clock enable for a single dot. It runs in the dot-clock domain. `dot_en` marks the cycles that carry a dot.

The word is assumed to be loaded into the memory's shift register during blanking, so the first word is valid when `blank` falls. While `blank` is high the block outputs a zero pixel, never requests a shift, and returns to the first pixel slot. It also takes the pixel depth for the coming line from `depth`. Three depths are supported: full width (4 bits, 8 pixels per 32-bit word), half width (16 pixels per word) and quarter width (32 pixels per word). Slot 0 is always taken from the least-significant bits of the word, and later slots move toward the most-significant bits.

Top module: `word_pixel_serializer`

## Requirements
- R1: With depth code 0 the pixel in slot s (0..7) equals `sr_word[4s+3:4s]`, and a word yields 8 pixels.
- R2: With depth code 1 the pixel in slot s (0..15) equals `{2'b00, sr_word[2s+1:2s]}`, and a word yields 16 pixels.
- R3: With depth code 2 the pixel in slot s (0..31) equals `{3'b000, sr_word[s]}`, and a word yields 32 pixels.
- R4: Depth code 3 behaves as code 0. `depth` is captured on each clock edge where `blank` is high and is held through active display, so a change while `blank` is low has no effect until the next blank.
- R5: The slot advances by one on a clock edge only when `dot_en` is high and `blank` is low. Otherwise the slot holds and the pixel output keeps showing the same slot of the current word.
- R6: While `blank` is high, `pixel` is 0 and `sclk_en` is 0, and every edge with `blank` high resets the slot to 0, so the first active dot shows slot 0.
- R7: `sclk_en` is high in exactly those cycles where `dot_en` is high, `blank` is low and the slot is the last one of the word. At the following edge the slot returns to 0.
- R8: During reset the slot is 0 and the depth is full width, so with `blank` low the pixel is `sr_word[3:0]` and `sclk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Marks a cycle that carries one dot |
| blank | input | 1 | High during horizontal or vertical blanking |
| depth | input | 2 | Pixel depth code: 0/3 full, 1 half, 2 quarter width |
| sr_word | input | WORD_W | Word on the memory's shift-out pins |
| pixel | output | PIX_W | Current pixel, zero-extended in narrow modes |
| sclk_en | output | 1 | One-dot request to shift the memory to the next word |

## Verification
The assertions check on every cycle that blanking forces a zero pixel and no shift request, and that a shift request only occurs on a dot cycle and never on two cycles in a row. They also check that the captured depth stays still during active display, that quarter-width pixels keep their upper bits clear, and that the first active dot after blanking shows slot 0. Only the bench scenarios can show that the pixels come out in the right order across many words at each depth. The same holds for correct pixel hold across gaps in `dot_en`, for lines that end partway through a word, and for a mid-line depth change being deferred to the next line.

// File: rtl/word_pixel_serializer.sv
module word_pixel_serializer #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic              blank,
  input  logic [1:0]        depth,
  input  logic [WORD_W-1:0] sr_word,
  output logic [PIX_W-1:0]  pixel,
  output logic              sclk_en
);

  localparam int SLOT_W = $clog2(WORD_W);
  localparam int PIX_SH = $clog2(PIX_W);
  localparam int SH_W   = $clog2(PIX_W) + 1;

  logic [1:0]        mode_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_last;
  logic [SLOT_W-1:0] base;
  logic [SH_W-1:0]   shamt;
  logic [PIX_W-1:0]  pix_raw;
  logic              last_dot;

  always_comb begin
    case (mode_q)
      2'd1:    shamt = SH_W'(PIX_SH - 1);
      2'd2:    shamt = SH_W'(PIX_SH - 2);
      default: shamt = SH_W'(PIX_SH);
    endcase
  end

  assign slot_last = SLOT_W'((WORD_W >> shamt) - 1);
  assign base      = SLOT_W'(slot_q << shamt);
  assign last_dot  = (slot_q == slot_last);

  for (genvar b = 0; b < PIX_W; b++) begin : g_bitsel
    assign pix_raw[b] = ((b >> shamt) == 0) ? sr_word[base + SLOT_W'(b)] : 1'b0;
  end

  assign pixel   = blank ? '0 : pix_raw;
  assign sclk_en = dot_en & ~blank & last_dot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      mode_q <= '0;
    end else if (blank) begin
      slot_q <= '0;
      mode_q <= depth;
    end else if (dot_en) begin
      slot_q <= last_dot ? '0 : slot_q + 1'b1;
    end
  end

endmodule

// File: rtl/word_pixel_serializer_chk.sv
module word_pixel_serializer_chk #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dot_en,
  input logic              blank,
  input logic              sclk_en,
  input logic [PIX_W-1:0]  pixel,
  input logic [WORD_W-1:0] sr_word,
  input logic [1:0]        mode_q
);

  localparam logic [PIX_W-1:0] M_FULL = '1;
  localparam logic [PIX_W-1:0] M_HALF = PIX_W'((1 << (PIX_W / 2)) - 1);
  localparam logic [PIX_W-1:0] M_QTR  = PIX_W'((1 << (PIX_W / 4)) - 1);

  logic [PIX_W-1:0] slot0_mask;
  assign slot0_mask = (mode_q == 2'd1) ? M_HALF : (mode_q == 2'd2) ? M_QTR : M_FULL;

  AST_BLANK_PIX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> pixel == '0); // R6
  AST_BLANK_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !sclk_en); // R6
  AST_SHIFT_ON_DOT: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> dot_en); // R7
  AST_SHIFT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |=> !sclk_en); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |=> $stable(mode_q)); // R4
  AST_QTR_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'd2 |-> (pixel & ~M_QTR) == '0); // R3
  AST_LINE_START_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && $past(blank)) |-> pixel == (sr_word[PIX_W-1:0] & slot0_mask)); // R6

endmodule

bind word_pixel_serializer word_pixel_serializer_chk #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/word_pixel_serializer_tb.sv
module word_pixel_serializer_tb;

  typedef struct {
    logic [3:0] pix;
    logic       sh;
    string      tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n;
  logic        dot_en;
  logic        blank;
  logic [1:0]  depth_in;
  logic [31:0] sr_word;
  logic [3:0]  pixel;
  logic        sclk_en;

  int          wp;
  int          line_start;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;
  exp_t        q[$];

  always #10 clk = ~clk;

  word_pixel_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .blank(blank),
    .depth(depth_in), .sr_word(sr_word), .pixel(pixel), .sclk_en(sclk_en)
  );

  function automatic logic [31:0] wgen(int i);
    return 32'h3C6E_F372 ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || blank) wp <= line_start;
    else if (sclk_en)    wp <= wp + 1;
  end
  assign sr_word = wgen(wp);

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pixel !== e.pix) begin
        fails++;
        $display("FAIL %s pixel act=%h exp=%h", e.tag, pixel, e.pix);
      end
      checks++;
      if (sclk_en !== e.sh) begin
        fails++;
        $display("FAIL R7 sclk_en (%s) act=%b exp=%b", e.tag, sclk_en, e.sh);
      end
    end
  end

  task automatic push(logic [3:0] p, logic s, string t);
    exp_t e;
    e.pix = p; e.sh = s; e.tag = t;
    q.push_back(e);
  endtask

  task automatic run_line(int d, int start, int ncyc, int gap, int chg_at, string tag);
    int bpp, ppw, k;
    bpp = (d == 1) ? 2 : (d == 2) ? 1 : 4;
    ppw = 32 / bpp;
    k = 0;
    line_start = start;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      blank = 1; dot_en = 1; depth_in = 2'(d);
      push(4'h0, 1'b0, "R6");
    end
    for (int c = 0; c < ncyc; c++) begin
      logic [31:0] w;
      int s;
      @(posedge clk); #1;
      blank = 0;
      dot_en = (gap > 0) ? ((c % gap) != gap - 1) : 1'b1;
      if (c == chg_at) depth_in = 2'd2;
      w = wgen(start + k / ppw);
      s = k % ppw;
      push(4'((w >> (s * bpp)) & ((32'd1 << bpp) - 1)), dot_en && (s == ppw - 1), tag);
      if (dot_en) k++;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; blank = 0; dot_en = 1; depth_in = 2'd2; line_start = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pixel !== wgen(0)[3:0]) begin
      fails++;
      $display("FAIL R8 reset pixel act=%h exp=%h", pixel, wgen(0)[3:0]);
    end
    checks++;
    if (sclk_en !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset sclk_en act=%b exp=0", sclk_en);
    end
    @(posedge clk); #1;
    rst_n = 1; blank = 1;

    run_line(0, 0,  24, 0, -1, "R1");
    run_line(1, 5,  40, 0, -1, "R2");
    run_line(2, 9,  70, 0, -1, "R3");
    run_line(3, 20, 19, 0, -1, "R4");
    run_line(0, 30, 30, 3, -1, "R5");
    run_line(1, 40, 37, 4, -1, "R5");
    run_line(0, 50, 21, 0,  5, "R4");
    run_line(2, 60, 35, 5, -1, "R3");
    run_line(0, 70, 5,  0, -1, "R6");
    run_line(0, 71, 9,  0, -1, "R7");

    @(posedge clk); #1;
    blank = 1;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule